// File: doc/BRIEF.md
# Sticky Pending Interrupt Controller

This block gathers a vector of interrupt request lines into a status register whose bits stay set once captured. A source that is high on any clock edge sets its bit, so a request lasting only one cycle is still recorded. Software acknowledges a request by writing a 1 to that bit of the status register (write-one-to-clear). If a source asserts on the same edge as the acknowledge of its bit, the bit stays pending, so no request is lost.

A mask register chooses which pending bits reach one combined, registered interrupt line to the processor. Masked bits are still captured in status. A parameter selects how mask writes behave: either the written value is loaded, or each written 1 flips the matching mask bit. Both register offsets are parameters, so one instance can sit at offsets 0x00/0x10 and another at 0x70/0x74 on a different processor side. The register port is a plain single-cycle access with no handshake: a write takes effect on the clock edge where `reg_wr` is high, and read data is a combinational function of `reg_addr`.

Top module: `irq_latch_ctrl`

## Requirements
- R1: Reset (active-low `rst_n`) clears status and mask to zero and drives `cpu_irq` low.
- R2: A status bit is set at every clock edge where its source input is high, and stays set until software clears it.
- R3: A write to the status offset clears each status bit written as 1; bits written as 0 keep their value.
- R4: When a source is high on the same edge as a write that clears its bit, the bit stays set.
- R5: A source pulse lasting a single clock cycle is captured into its status bit.
- R6: `cpu_irq` is registered: after each edge it equals the OR of (status AND mask) as they stood before that edge.
- R7: A masked source is still latched into status; unmasking it while still pending raises `cpu_irq` one edge after the mask changes.
- R8: With the mask mode set to load (default), a write to the mask offset replaces the mask with the low 16 bits of the write data.
- R9: With the mask mode set to toggle, a write to the mask offset flips each mask bit whose write-data bit is 1.
- R10: A read at the status or mask offset returns that register in bits 15:0 with bits 31:16 zero; reads at any other offset return zero, and writes at any other offset change nothing.
- R11: Register offsets are parameters (defaults: status 0x00, mask 0x10); an instance with status at 0x70 and mask at 0x74 responds only at those offsets.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe, one write per high cycle |
| reg_addr | input | 8 | Register offset for read and write |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Read data for `reg_addr`, combinational |
| irq_src | input | 16 | Interrupt source lines, one per status bit |
| cpu_irq | output | 1 | Combined masked interrupt to the processor |

## Verification
The assertions assume the inputs are settled at every rising edge and that reset is held for at least one edge before the first check; the bench changes every input a short time after the edge and holds reset for several cycles. They also assume the two offsets differ, which holds for both instances the bench builds. The stimulus holds the write strobe for single cycles and places the set-versus-clear collision, the single-cycle pulse and the toggle writes in separate cycles, so each case shows alone at the outputs.

// File: rtl/irq_pkg.sv
package irq_pkg;

  // How a write to the mask offset combines with the held mask.
  typedef enum logic {
    MASK_LOAD   = 1'b0,
    MASK_TOGGLE = 1'b1
  } mask_mode_e;

endpackage

// File: rtl/irq_pend_bank.sv
module irq_pend_bank #(
  parameter int NUM_SRC = 16
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic [NUM_SRC-1:0] clr_i,
  output logic [NUM_SRC-1:0] stat_o
);

  logic [NUM_SRC-1:0] stat_q;

  // Per-bit latch: set dominates clear so a fresh request survives an ack.
  for (genvar b = 0; b < NUM_SRC; b++) begin : g_bit
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
        stat_q[b] <= 1'b0;
      else if (src_i[b])
        stat_q[b] <= 1'b1;
      else if (clr_i[b])
        stat_q[b] <= 1'b0;
    end
  end

  assign stat_o = stat_q;

  // R2: a set bit that was not cleared stays set
  a_r2_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & ($past(stat_q) & ~$past(clr_i))) == ($past(stat_q) & ~$past(clr_i))));

  // R4 / R5: any source seen high is pending on the next cycle
  a_r4_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(src_i)) == $past(src_i)));

  // R3: a cleared bit with no concurrent source goes low
  a_r3_clear: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> ((stat_q & $past(clr_i) & ~$past(src_i)) == '0));

endmodule

// File: rtl/irq_mask_reg.sv
module irq_mask_reg
  import irq_pkg::*;
#(
  parameter int         NUM_SRC   = 16,
  parameter mask_mode_e MASK_MODE = MASK_LOAD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               wr_en,
  input  logic [NUM_SRC-1:0] wdata,
  output logic [NUM_SRC-1:0] mask_o
);

  logic [NUM_SRC-1:0] mask_q;
  logic [NUM_SRC-1:0] mask_nxt;

  if (MASK_MODE == MASK_TOGGLE) begin : g_toggle
    assign mask_nxt = mask_q ^ wdata;

    // R9: toggle write flips the written-one bits
    a_r9_mask_toggle: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mask_q == ($past(mask_q) ^ $past(wdata))));
  end else begin : g_load
    assign mask_nxt = wdata;

    // R8: load write replaces the mask
    a_r8_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> (mask_q == $past(wdata)));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      mask_q <= '0;
    else if (wr_en)
      mask_q <= mask_nxt;
  end

  assign mask_o = mask_q;

  // R10: without a mask write the mask holds
  a_r10_mask_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/irq_read_mux.sv
module irq_read_mux #(
  parameter int                NUM_SRC  = 16,
  parameter int                ADDR_W   = 8,
  parameter int                DATA_W   = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS = 'h00,
  parameter logic [ADDR_W-1:0] MASK_OFS = 'h10
) (
  input  logic [ADDR_W-1:0]  addr_i,
  input  logic [NUM_SRC-1:0] stat_i,
  input  logic [NUM_SRC-1:0] mask_i,
  output logic [DATA_W-1:0]  rdata_o
);

  localparam int PAD_W = DATA_W - NUM_SRC;

  always_comb begin
    rdata_o = '0;
    if (addr_i == STAT_OFS)
      rdata_o = {{PAD_W{1'b0}}, stat_i};
    else if (addr_i == MASK_OFS)
      rdata_o = {{PAD_W{1'b0}}, mask_i};
  end

endmodule

// File: rtl/irq_latch_ctrl.sv
module irq_latch_ctrl
  import irq_pkg::*;
#(
  parameter int                NUM_SRC   = 16,
  parameter int                ADDR_W    = 8,
  parameter int                DATA_W    = 32,
  parameter logic [ADDR_W-1:0] STAT_OFS  = 'h00,
  parameter logic [ADDR_W-1:0] MASK_OFS  = 'h10,
  parameter mask_mode_e        MASK_MODE = MASK_LOAD
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               reg_wr,
  input  logic [ADDR_W-1:0]  reg_addr,
  input  logic [DATA_W-1:0]  reg_wdata,
  output logic [DATA_W-1:0]  reg_rdata,
  input  logic [NUM_SRC-1:0] irq_src,
  output logic               cpu_irq
);

  logic               stat_wr;
  logic               mask_wr;
  logic [NUM_SRC-1:0] clr_vec;
  logic [NUM_SRC-1:0] stat;
  logic [NUM_SRC-1:0] mask;
  logic               irq_q;

  assign stat_wr = reg_wr && (reg_addr == STAT_OFS);
  assign mask_wr = reg_wr && (reg_addr == MASK_OFS);
  assign clr_vec = stat_wr ? reg_wdata[NUM_SRC-1:0] : '0;

  irq_pend_bank #(.NUM_SRC(NUM_SRC)) u_pend (
    .clk    (clk),
    .rst_n  (rst_n),
    .src_i  (irq_src),
    .clr_i  (clr_vec),
    .stat_o (stat)
  );

  irq_mask_reg #(.NUM_SRC(NUM_SRC), .MASK_MODE(MASK_MODE)) u_mask (
    .clk    (clk),
    .rst_n  (rst_n),
    .wr_en  (mask_wr),
    .wdata  (reg_wdata[NUM_SRC-1:0]),
    .mask_o (mask)
  );

  irq_read_mux #(
    .NUM_SRC  (NUM_SRC),
    .ADDR_W   (ADDR_W),
    .DATA_W   (DATA_W),
    .STAT_OFS (STAT_OFS),
    .MASK_OFS (MASK_OFS)
  ) u_rd (
    .addr_i  (reg_addr),
    .stat_i  (stat),
    .mask_i  (mask),
    .rdata_o (reg_rdata)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      irq_q <= 1'b0;
    else
      irq_q <= |(stat & mask);
  end

  assign cpu_irq = irq_q;

  // R6 / R7: combined line follows masked pending state one edge later
  a_r6_irq_follow: assert property (@(posedge clk) disable iff (!rst_n)
    1'b1 |=> (cpu_irq == |($past(stat) & $past(mask))));

  // R1: no pending bits means the line drops on the next edge
  a_r1_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (stat == '0) |=> !cpu_irq);

endmodule

// File: tb/sim_irq_latch_ctrl.sv
module sim_irq_latch_ctrl;
  import irq_pkg::*;

  typedef struct packed {
    logic        wr;
    logic [7:0]  addr;
    logic [31:0] wdata;
    logic [15:0] src;
    logic [15:0] e_stat;
    logic [15:0] e_mask;
    logic        e_irq;
  } vec_t;

  localparam int NVEC = 16;
  localparam vec_t VEC [NVEC] = '{
    '{1'b0, 8'h00, 32'h0000_0000, 16'h0001, 16'h0001, 16'h0000, 1'b0}, // R2 set
    '{1'b1, 8'h10, 32'h0000_0003, 16'h0000, 16'h0001, 16'h0003, 1'b0}, // R8 load
    '{1'b0, 8'h00, 32'h0000_0000, 16'h0000, 16'h0001, 16'h0003, 1'b1}, // R6
    '{1'b1, 8'h00, 32'h0000_0001, 16'h0000, 16'h0000, 16'h0003, 1'b1}, // R3 clear
    '{1'b0, 8'h00, 32'h0000_0000, 16'h0000, 16'h0000, 16'h0003, 1'b0}, // R6 drop
    '{1'b0, 8'h00, 32'h0000_0000, 16'h8000, 16'h8000, 16'h0003, 1'b0}, // R7 masked
    '{1'b0, 8'h00, 32'h0000_0000, 16'h0000, 16'h8000, 16'h0003, 1'b0}, // R7
    '{1'b1, 8'h10, 32'h0000_8000, 16'h0000, 16'h8000, 16'h8000, 1'b0}, // R7 unmask
    '{1'b0, 8'h00, 32'h0000_0000, 16'h0000, 16'h8000, 16'h8000, 1'b1}, // R7 raise
    '{1'b1, 8'h00, 32'h0000_8000, 16'h8000, 16'h8000, 16'h8000, 1'b1}, // R4 collide
    '{1'b1, 8'h00, 32'h0000_0000, 16'h0000, 16'h8000, 16'h8000, 1'b1}, // R3 zeros
    '{1'b1, 8'h00, 32'hFFFF_FFFF, 16'h0002, 16'h0002, 16'h8000, 1'b1}, // R4 multi
    '{1'b0, 8'h00, 32'h0000_0000, 16'h0000, 16'h0002, 16'h8000, 1'b0}, // R6
    '{1'b1, 8'h04, 32'h0000_FFFF, 16'h0000, 16'h0002, 16'h8000, 1'b0}, // R10 ignored
    '{1'b1, 8'h10, 32'hABCD_0006, 16'h0000, 16'h0002, 16'h0006, 1'b0}, // R8 low bits
    '{1'b0, 8'h00, 32'h0000_0000, 16'h0000, 16'h0002, 16'h0006, 1'b1}  // R6
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr0 = 1'b0, wr1 = 1'b0;
  logic [7:0]  addr0 = '0, addr1 = '0;
  logic [31:0] wdata0 = '0, wdata1 = '0;
  logic [31:0] rdata0, rdata1;
  logic [15:0] src0 = '0, src1 = '0;
  logic        irq0, irq1;
  int          checks = 0;
  int          errors = 0;
  bit          done = 1'b0;

  always #2.5 clk = ~clk;

  irq_latch_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr0), .reg_addr(addr0),
    .reg_wdata(wdata0), .reg_rdata(rdata0), .irq_src(src0), .cpu_irq(irq0)
  );

  irq_latch_ctrl #(.STAT_OFS(8'h70), .MASK_OFS(8'h74), .MASK_MODE(MASK_TOGGLE)) u1 (
    .clk(clk), .rst_n(rst_n), .reg_wr(wr1), .reg_addr(addr1),
    .reg_wdata(wdata1), .reg_rdata(rdata1), .irq_src(src1), .cpu_irq(irq1)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #1;
  endtask

  task automatic rd0(input logic [7:0] a, output logic [31:0] d);
    addr0 = a; wr0 = 1'b0;
    #0.5;
    d = rdata0;
  endtask

  task automatic rd1(input logic [7:0] a, output logic [31:0] d);
    addr1 = a; wr1 = 1'b0;
    #0.5;
    d = rdata1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    logic [31:0] d;
    repeat (4) @(posedge clk);
    #1;
    // R1: reset state
    rd0(8'h00, d); chk("R1 stat", d, 32'h0);
    rd0(8'h10, d); chk("R1 mask", d, 32'h0);
    chk("R1 irq", {31'b0, irq0}, 32'h0);
    rst_n = 1'b1;
    tick();

    for (int i = 0; i < NVEC; i++) begin
      wr0 = VEC[i].wr; addr0 = VEC[i].addr; wdata0 = VEC[i].wdata; src0 = VEC[i].src;
      tick();
      wr0 = 1'b0; src0 = '0; wdata0 = '0;
      rd0(8'h00, d); chk($sformatf("R2/R3/R4 vec%0d stat", i), d, {16'h0, VEC[i].e_stat});
      rd0(8'h10, d); chk($sformatf("R8/R10 vec%0d mask", i), d, {16'h0, VEC[i].e_mask});
      chk($sformatf("R6/R7 vec%0d irq", i), {31'b0, irq0}, {31'b0, VEC[i].e_irq});
    end

    // R10: unmapped offset reads zero while status is nonzero
    rd0(8'h20, d); chk("R10 unmapped read", d, 32'h0);

    // R11 / R5: second instance, single-cycle pulse
    src1 = 16'h0040;
    tick();
    src1 = '0;
    tick();
    rd1(8'h70, d); chk("R5 R11 pulse latched", d, 32'h0000_0040);
    rd1(8'h00, d); chk("R11 default offset unused", d, 32'h0);
    // R9: toggle writes
    wr1 = 1'b1; addr1 = 8'h74; wdata1 = 32'h0000_0041;
    tick();
    wr1 = 1'b1; addr1 = 8'h74; wdata1 = 32'h0000_0001;
    tick();
    wr1 = 1'b0; wdata1 = '0;
    rd1(8'h74, d); chk("R9 toggle mask", d, 32'h0000_0040);
    chk("R9 irq after first toggle", {31'b0, irq1}, 32'h1);
    // R11: write at the default mask offset is ignored on this instance
    wr1 = 1'b1; addr1 = 8'h10; wdata1 = 32'h0000_FFFF;
    tick();
    wr1 = 1'b0;
    rd1(8'h74, d); chk("R11 foreign offset ignored", d, 32'h0000_0040);
    chk("R6 u1 irq held", {31'b0, irq1}, 32'h1);

    // R1: reset in the middle of operation
    rst_n = 1'b0;
    #1;
    rd0(8'h00, d); chk("R1 mid reset stat", d, 32'h0);
    rd0(8'h10, d); chk("R1 mid reset mask", d, 32'h0);
    chk("R1 mid reset irq", {31'b0, irq0}, 32'h0);
    chk("R1 mid reset u1 irq", {31'b0, irq1}, 32'h0);
    tick();
    rst_n = 1'b1;
    tick();
    finish_run();
  end

endmodule